// File: doc/BRIEF.md
# JTAG Configuration and Safe-State Controller

This block is the test access port of a supervisory device whose behaviour comes from a nonvolatile configuration array. A standard 16-state TAP state machine runs on TCK. A 5-bit instruction register picks one of a private set of operations: loading a column address, loading or reading back a column of configuration data, erasing and programming the array, bulk-erasing all nonvolatile content, erasing the user signature, entering and leaving programming mode, reading a 32-bit identification code, reading the signature bits, and capturing a 12-bit word from the voltage comparators.

Every instruction that touches the configuration array also raises a safe-state flag. The pad drivers outside the block use this flag to turn off all their open-drain transistors and to pull FET-driver pins low. Destructive actions leave the block as one-cycle strobes to an external memory interface. Each strobe fires only on the second rising TCK edge spent in Run-Test-Idle, and only while a separate programming-mode latch is set. The memory, the comparators and the pad drivers are not part of this block; they appear only as ports.

Top module: `cfg_tap_ctrl`

## Requirements
- R1: The instruction register is 5 bits wide and is loaded LSB first. When Update-IR loads any of these opcodes, `safe_state` goes high from the next TCK cycle: 01 address-set, 02 data-load, 03 array erase, 04 column program, 05 column read, 06 bulk erase, 08 program-enable, 0C signature erase. `safe_state` stays low for 09 ID, 0A program-disable, 0B status, 0D signature read and every unused opcode. `safe_state` is low after reset.
- R2: Opcode 07 (safe instruction) drives `safe_state` high once the TAP has passed through Update-IR.
- R3: Each of the four strobes is a one-cycle pulse. It is visible in the cycle after the second rising TCK edge spent in Run-Test-Idle. A visit to Run-Test-Idle that lasts one edge fires nothing, and a longer visit fires only once.
- R4: All four strobes are suppressed while `prog_mode` is low. The mapping is: 03 gives `erase_stb`, 04 gives `prog_stb`, 06 gives `bulk_stb`, 0C gives `sig_erase_stb`.
- R5: `prog_mode` is set when Update-IR loads opcode 08. It is cleared when Update-IR loads opcode 0A, in Test-Logic-Reset, and by reset.
- R6: Opcode 0B selects a 12-bit status register that captures `cmp_in` in Capture-DR. Status bit 11 holds channel 1 (`cmp_in[0]`) and bit 0 holds channel 12 (`cmp_in[11]`). The register shifts LSB first, so channel 12 is the first bit on TDO.
- R7: Opcode 09 selects a 32-bit register that captures `ID_VALUE`. Test-Logic-Reset loads opcode 09 into the instruction register, so a DR scan made straight after reset returns the ID.
- R8: Opcode 0D selects a `SIG_W`-bit register that captures `sig_in` in Capture-DR.
- R9: Opcode 01 selects an `ADDR_W`-bit register. It captures the current `col_addr`, and Update-DR copies the shifted value into `col_addr`, which holds across later instructions. Opcode 02 does the same with a `COL_W`-bit register and `cfg_wdata`. Opcode 05 captures `cfg_rdata` into a `COL_W`-bit register.
- R10: Every opcode not listed in R6 to R9 selects a 1-bit bypass register that captures 0. An n-bit scan therefore returns a 0 followed by the first n-1 TDI bits.
- R11: `tdo` and `tdo_en` change on the falling edge of TCK, and `tdo_en` is high only in Shift-IR and Shift-DR. In Capture-IR the instruction shift register captures 00001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for TDO |
| cmp_in | input | CMP_N | Comparator outputs, bit k is channel k+1 |
| sig_in | input | SIG_W | Signature bits read from memory |
| cfg_rdata | input | COL_W | Content of the addressed configuration column |
| col_addr | output | ADDR_W | Held column address |
| cfg_wdata | output | COL_W | Held column data for programming |
| safe_state | output | 1 | Forces all output drivers to their safe level |
| prog_mode | output | 1 | Programming-mode latch |
| erase_stb | output | 1 | Configuration array erase strobe |
| prog_stb | output | 1 | Column program strobe |
| bulk_stb | output | 1 | Bulk erase strobe for all nonvolatile content |
| sig_erase_stb | output | 1 | Signature memory erase strobe |

## Verification
The assertions assume that `trst_n` is held low at start-up until the first TCK edge, so that the TAP and latch start from a known point. They also assume that `tms` and `tdi` are stable around each rising edge. The status, signature and read-data inputs are taken to be steady during Capture-DR. The stimulus changes every input only on the falling edge of TCK. It sets the data inputs before a scan starts and leaves them untouched until the scan ends. All TAP movement comes from fixed TMS walks, so the state machine is never steered through an undefined path.

// File: rtl/cfg_tap_ctrl.sv
module cfg_tap_ctrl #(
  parameter int          ADDR_W   = 6,
  parameter int          COL_W    = 16,
  parameter int          SIG_W    = 16,
  parameter int          CMP_N    = 12,
  parameter logic [31:0] ID_VALUE = 32'h1A2B_C043
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic [CMP_N-1:0]  cmp_in,
  input  logic [SIG_W-1:0]  sig_in,
  input  logic [COL_W-1:0]  cfg_rdata,
  output logic [ADDR_W-1:0] col_addr,
  output logic [COL_W-1:0]  cfg_wdata,
  output logic              safe_state,
  output logic              prog_mode,
  output logic              erase_stb,
  output logic              prog_stb,
  output logic              bulk_stb,
  output logic              sig_erase_stb
);

  localparam int IR_W  = 5;
  localparam int W_A   = (COL_W > 32) ? COL_W : 32;
  localparam int W_B   = (SIG_W > W_A) ? SIG_W : W_A;
  localparam int W_C   = (ADDR_W > W_B) ? ADDR_W : W_B;
  localparam int DR_W  = (CMP_N > W_C) ? CMP_N : W_C;
  localparam int LEN_W = $clog2(DR_W);

  localparam logic [IR_W-1:0] OP_ADDR  = 5'h01;
  localparam logic [IR_W-1:0] OP_DATA  = 5'h02;
  localparam logic [IR_W-1:0] OP_ERASE = 5'h03;
  localparam logic [IR_W-1:0] OP_PROG  = 5'h04;
  localparam logic [IR_W-1:0] OP_READ  = 5'h05;
  localparam logic [IR_W-1:0] OP_BULK  = 5'h06;
  localparam logic [IR_W-1:0] OP_SAFE  = 5'h07;
  localparam logic [IR_W-1:0] OP_PEN   = 5'h08;
  localparam logic [IR_W-1:0] OP_ID    = 5'h09;
  localparam logic [IR_W-1:0] OP_PDIS  = 5'h0A;
  localparam logic [IR_W-1:0] OP_STAT  = 5'h0B;
  localparam logic [IR_W-1:0] OP_SERA  = 5'h0C;
  localparam logic [IR_W-1:0] OP_SIG   = 5'h0D;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UPD_IR
  } tap_t;

  tap_t              state, state_nx;
  logic [IR_W-1:0]   ir, ir_sr;
  logic [DR_W-1:0]   dr, dr_shift, cap_val;
  logic [LEN_W-1:0]  dr_msb;
  logic [CMP_N-1:0]  stat_word;
  logic [1:0]        rti_cnt;
  logic              fire;

  function automatic logic forces_safe(input logic [IR_W-1:0] op);
    return op inside {OP_ADDR, OP_DATA, OP_ERASE, OP_PROG, OP_READ,
                      OP_BULK, OP_SAFE, OP_PEN, OP_SERA};
  endfunction

  always_comb begin
    case (state)
      S_TLR:    state_nx = tms ? S_TLR    : S_RTI;
      S_RTI:    state_nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_nx = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_nx = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_nx = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_nx = tms ? S_UPD_DR : S_PA_DR;
      S_PA_DR:  state_nx = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: state_nx = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_nx = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_nx = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_nx = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_nx = tms ? S_UPD_IR : S_PA_IR;
      S_PA_IR:  state_nx = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: state_nx = tms ? S_UPD_IR : S_SH_IR;
      default:  state_nx = tms ? S_SEL_DR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= state_nx;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir    <= OP_ID;
      ir_sr <= '0;
    end else begin
      case (state)
        S_TLR:    ir    <= OP_ID;
        S_CAP_IR: ir_sr <= IR_W'(1);
        S_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        S_UPD_IR: ir    <= ir_sr;
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                                  prog_mode <= 1'b0;
    else if (state == S_TLR)                      prog_mode <= 1'b0;
    else if (state == S_UPD_IR && ir_sr == OP_PEN)  prog_mode <= 1'b1;
    else if (state == S_UPD_IR && ir_sr == OP_PDIS) prog_mode <= 1'b0;
  end

  assign safe_state = forces_safe(ir);

  always_comb
    for (int k = 0; k < CMP_N; k++) stat_word[CMP_N-1-k] = cmp_in[k];

  always_comb begin
    case (ir)
      OP_ADDR: begin dr_msb = LEN_W'(ADDR_W-1); cap_val = DR_W'(col_addr);  end
      OP_DATA: begin dr_msb = LEN_W'(COL_W-1);  cap_val = DR_W'(cfg_wdata); end
      OP_READ: begin dr_msb = LEN_W'(COL_W-1);  cap_val = DR_W'(cfg_rdata); end
      OP_ID:   begin dr_msb = LEN_W'(31);       cap_val = DR_W'(ID_VALUE);  end
      OP_STAT: begin dr_msb = LEN_W'(CMP_N-1);  cap_val = DR_W'(stat_word); end
      OP_SIG:  begin dr_msb = LEN_W'(SIG_W-1);  cap_val = DR_W'(sig_in);    end
      default: begin dr_msb = '0;               cap_val = '0;               end
    endcase
    dr_shift         = dr >> 1;
    dr_shift[dr_msb] = tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dr        <= '0;
      col_addr  <= '0;
      cfg_wdata <= '0;
    end else begin
      case (state)
        S_CAP_DR: dr <= cap_val;
        S_SH_DR:  dr <= dr_shift;
        S_UPD_DR: begin
          if (ir == OP_ADDR) col_addr  <= dr[ADDR_W-1:0];
          if (ir == OP_DATA) cfg_wdata <= dr[COL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (state == S_SH_IR) ? ir_sr[0] : (state == S_SH_DR) ? dr[0] : 1'b0;
      tdo_en <= (state == S_SH_IR) || (state == S_SH_DR);
    end
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)              rti_cnt <= '0;
    else if (state != S_RTI)  rti_cnt <= '0;
    else if (rti_cnt != 2'd2) rti_cnt <= rti_cnt + 2'd1;

  assign fire = (state == S_RTI) && (rti_cnt == 2'd1) && prog_mode;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      erase_stb     <= 1'b0;
      prog_stb      <= 1'b0;
      bulk_stb      <= 1'b0;
      sig_erase_stb <= 1'b0;
    end else begin
      erase_stb     <= fire && (ir == OP_ERASE);
      prog_stb      <= fire && (ir == OP_PROG);
      bulk_stb      <= fire && (ir == OP_BULK);
      sig_erase_stb <= fire && (ir == OP_SERA);
    end
  end

  logic any_stb;
  assign any_stb = erase_stb | prog_stb | bulk_stb | sig_erase_stb;

  assert_stb_pulse_R3: assert property (@(posedge tck) disable iff (!trst_n)
    any_stb |=> !any_stb);

  assert_stb_second_edge_R3: assert property (@(posedge tck) disable iff (!trst_n)
    any_stb |-> ($past(state) == S_RTI && $past(state, 2) == S_RTI && $past(state, 3) != S_RTI));

  assert_stb_onehot_R4: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({erase_stb, prog_stb, bulk_stb, sig_erase_stb}));

  assert_stb_needs_prog_R4: assert property (@(posedge tck) disable iff (!trst_n)
    any_stb |-> prog_mode);

  assert_tlr_clears_prog_R5: assert property (@(posedge tck) disable iff (!trst_n)
    state == S_TLR |=> !prog_mode);

  assert_safe_after_update_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_UPD_IR && forces_safe(ir_sr)) |=> safe_state);

  assert_tdo_en_shift_only_R11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == S_SH_DR || state == S_SH_IR));

endmodule

// File: tb/test_cfg_tap_ctrl.sv
`timescale 1ns/100ps
module test_cfg_tap_ctrl;
  localparam int          ADDR_W = 6;
  localparam int          COL_W  = 16;
  localparam int          SIG_W  = 16;
  localparam int          CMP_N  = 12;
  localparam logic [31:0] ID_V   = 32'h5E7A_90C1;

  logic tck = 1'b0;
  always #2.5 tck = ~tck;

  logic trst_n, tms, tdi, tdo, tdo_en;
  logic [CMP_N-1:0]  cmp_in;
  logic [SIG_W-1:0]  sig_in;
  logic [COL_W-1:0]  cfg_rdata, cfg_wdata;
  logic [ADDR_W-1:0] col_addr;
  logic safe_state, prog_mode, erase_stb, prog_stb, bulk_stb, sig_erase_stb;

  cfg_tap_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W), .SIG_W(SIG_W), .CMP_N(CMP_N), .ID_VALUE(ID_V))
    i_cfg_tap_ctrl (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
      .cmp_in(cmp_in), .sig_in(sig_in), .cfg_rdata(cfg_rdata), .col_addr(col_addr),
      .cfg_wdata(cfg_wdata), .safe_state(safe_state), .prog_mode(prog_mode),
      .erase_stb(erase_stb), .prog_stb(prog_stb), .bulk_stb(bulk_stb),
      .sig_erase_stb(sig_erase_stb));

  typedef enum int {K_STB, K_SAFE, K_PMODE, K_SCAN, K_ADDR, K_WDATA, K_EN, K_ENSH} kind_t;
  typedef struct {int at; kind_t kind; logic [31:0] exp; string req;} item_t;

  item_t       sbq[$];
  int          cyc = 0;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] last_scan = '0;
  logic        last_en_all = 1'b0;
  logic        tdo_s, en_s;

  always @(posedge tck) cyc++;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(int ahead, kind_t k, logic [31:0] e, string req);
    sbq.push_back('{cyc + ahead, k, e, req});
  endtask

  always @(negedge tck) begin : monitor
    item_t it;
    logic [3:0] stbv;
    bit seen;
    #1.2;
    seen = 0;
    stbv = {sig_erase_stb, bulk_stb, prog_stb, erase_stb};
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      it = sbq.pop_front();
      case (it.kind)
        K_STB:   begin seen = 1; check(it.req, "strobes", 32'(stbv), it.exp); end
        K_SAFE:  check(it.req, "safe_state", 32'(safe_state), it.exp);
        K_PMODE: check(it.req, "prog_mode", 32'(prog_mode), it.exp);
        K_SCAN:  check(it.req, "scan data", last_scan, it.exp);
        K_ADDR:  check(it.req, "col_addr", 32'(col_addr), it.exp);
        K_WDATA: check(it.req, "cfg_wdata", 32'(cfg_wdata), it.exp);
        K_EN:    check(it.req, "tdo_en", 32'(tdo_en), it.exp);
        default: check(it.req, "tdo_en in shift", 32'(last_en_all), it.exp);
      endcase
    end
    if (!seen && stbv != 4'b0) check("R3", "unexpected strobe", 32'(stbv), 32'h0);
  end

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    #1;
    tdo_s = tdo;
    en_s  = tdo_en;
    @(negedge tck);
  endtask

  task automatic shift_ir(input logic [4:0] op, input bit chk);
    logic [31:0] cap = '0;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, op[i]);
      cap[i] = tdo_s;
    end
    last_scan = cap;
    if (chk) push(1, K_SCAN, 32'h1, "R11");
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, input logic [31:0] exp, input string req);
    logic [31:0] dout = '0;
    logic all_en = 1'b1;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = tdo_s;
      all_en &= en_s;
    end
    last_scan   = dout;
    last_en_all = all_en;
    push(1, K_SCAN, exp, req);
    push(1, K_ENSH, 32'h1, "R11");
    step(1, 0); step(0, 0);
  endtask

  task automatic idle_check(input logic [3:0] exp, input string req);
    push(1, K_STB, 32'h0, req);
    push(2, K_STB, 32'(exp), req);
    push(3, K_STB, 32'h0, req);
    push(4, K_STB, 32'h0, req);
    repeat (4) step(0, 0);
  endtask

  function automatic logic [31:0] rev12(input logic [11:0] v);
    logic [31:0] r = '0;
    for (int k = 0; k < 12; k++) r[11-k] = v[k];
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge tck);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : driver
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    cmp_in = 12'hA5C; sig_in = 16'hC3A5; cfg_rdata = 16'h1234;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    push(1, K_SAFE, 0, "R1"); push(1, K_PMODE, 0, "R5");
    push(1, K_STB, 0, "R3");  push(1, K_EN, 0, "R11");
    step(1, 0);
    step(0, 0);
    shift_dr(32, 32'h0, ID_V, "R7");
    shift_ir(5'h09, 1);
    push(1, K_EN, 0, "R11");
    shift_ir(5'h0B, 0);
    push(1, K_SAFE, 0, "R1");
    shift_dr(12, 0, rev12(12'hA5C), "R6");
    cmp_in = 12'h001;
    shift_dr(12, 0, 32'h800, "R6");

    shift_ir(5'h03, 0);
    push(1, K_SAFE, 1, "R1");
    idle_check(4'b0000, "R4");
    shift_ir(5'h06, 0); idle_check(4'b0000, "R4");
    shift_ir(5'h0C, 0); idle_check(4'b0000, "R4");

    shift_ir(5'h08, 0);
    push(1, K_SAFE, 1, "R1"); push(1, K_PMODE, 1, "R5");
    step(0, 0);
    shift_ir(5'h03, 0);
    push(1, K_STB, 0, "R3");
    step(1, 0); step(0, 0); step(1, 0); step(1, 0); step(0, 0);
    idle_check(4'b0001, "R3");

    shift_ir(5'h01, 0);
    shift_dr(ADDR_W, 32'h2B, 32'h0, "R9");
    push(1, K_ADDR, 32'h2B, "R9");
    shift_ir(5'h02, 0);
    shift_dr(COL_W, 32'hBEEF, 32'h0, "R9");
    push(1, K_WDATA, 32'hBEEF, "R9");
    shift_dr(COL_W, 32'h0, 32'hBEEF, "R9");
    shift_ir(5'h04, 0); idle_check(4'b0010, "R4");
    shift_ir(5'h05, 0);
    shift_dr(COL_W, 32'h0, 32'h1234, "R9");
    push(1, K_ADDR, 32'h2B, "R9");
    shift_ir(5'h06, 0); idle_check(4'b0100, "R4");
    shift_ir(5'h0C, 0); idle_check(4'b1000, "R4");

    shift_ir(5'h0D, 0);
    push(1, K_SAFE, 0, "R1");
    shift_dr(SIG_W, 32'h0, 32'hC3A5, "R8");
    shift_ir(5'h07, 0);
    push(1, K_SAFE, 1, "R2");
    step(0, 0);
    shift_ir(5'h0A, 0);
    push(1, K_PMODE, 0, "R5"); push(1, K_SAFE, 0, "R1");
    step(0, 0);
    shift_ir(5'h03, 0); idle_check(4'b0000, "R4");

    shift_ir(5'h08, 0);
    push(1, K_PMODE, 1, "R5");
    step(0, 0);
    repeat (5) step(1, 0);
    push(1, K_PMODE, 0, "R5");
    step(1, 0);
    step(0, 0);
    shift_dr(32, 32'h0, ID_V, "R7");
    shift_ir(5'h03, 0); idle_check(4'b0000, "R5");

    shift_ir(5'h1F, 0);
    shift_dr(8, 32'hA6, 32'h4C, "R10");
    shift_ir(5'h00, 0);
    shift_dr(8, 32'h3B, 32'h76, "R10");
    push(1, K_SAFE, 0, "R10");
    repeat (3) step(0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule